// File: doc/BRIEF.md
# Serial Configuration EEPROM Auto-Loader

After reset this block reads the whole contents of a three-wire serial EEPROM into the chip, one word at a time, without any host request. It generates the chip select, a shift clock at a quarter of the core clock, and the serial command stream toward the memory. It samples the serial data coming back. Each 16-bit word comes out on a simple write port: an address, a data word and a one-cycle valid strobe. The surrounding logic uses that port to fill its configuration registers.

The block does not know the memory size in advance. Its first access is a read of address zero. During that read it keeps sending zero address bits until the memory answers with a low "dummy" bit. The number of address bits sent up to that point is the address width of the part. The data word from that first read is kept as word 0. The block then reads every remaining address in ascending order. When the last word has been written it raises a done flag. If the memory gives no usable answer, the block stops and raises a fault flag instead.

Top module: `mwl_autoload`

## Requirements
- R1: While rstN is low, eeCs, eeSk, eeDi, wordValid, loadDone and loadFault are all 0 and addrWidth is 0.
- R2: eeSk toggles only while eeCs is 1. Each period is four core cycles: two low, then two high. eeDi changes only while eeSk is low. eeDo is captured one core cycle after each rising edge of eeSk.
- R3: Every read frame sends a start bit of 1 and then the read opcode 2'b10. It then sends the W-bit word address, most significant bit first, and then shifts in 16 data bits. The first data bit received lands in bit 15 of wordData.
- R4: During the first frame after reset, every address bit sent is 0. W is the number of address bits sent up to and including the one after which eeDo is first sampled as 0. Samples taken during the start and opcode bits do not count. W is shown on addrWidth from then until the next reset.
- R5: The data read during the detection frame is delivered as the word at address 0.
- R6: Addresses 0 to 2^W-1 are each delivered exactly once, in ascending order. wordValid is high for exactly one core cycle per word, with that word's wordAddr and wordData.
- R7: Before each rising edge of eeCs, eeCs has been low for at least 8 core cycles (two shift-clock periods). This includes the first frame after reset.
- R8: loadDone rises in the same cycle as the final wordValid and stays high until reset. From then on eeCs stays low and addrWidth does not change.
- R9: Any of the following stops the block with loadFault high until reset: eeDo reads 0 after fewer than 6 address bits, or eeDo is still 1 after 8 address bits. In that case no word is delivered, addrWidth stays 0 and eeCs stays low. loadFault rises 4*(5+n) core cycles after reset release, where n is the number of address bits sent.
- R10: Count core clock edges from reset release, with the first edge as 1. Word k is strobed at edge 4*(21+W)*(k+1). A 64-word part therefore finishes at edge 6912.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| eeCs | output | 1 | EEPROM chip select, active high |
| eeSk | output | 1 | EEPROM shift clock, a quarter of the core rate |
| eeDi | output | 1 | Serial command and address toward the EEPROM |
| eeDo | input | 1 | Serial data from the EEPROM (reads 1 when not driven) |
| wordValid | output | 1 | One-cycle strobe for a loaded word |
| wordAddr | output | MAX_AW (8) | Address of the loaded word |
| wordData | output | DATA_W (16) | Loaded data word |
| loadDone | output | 1 | All words loaded; held until reset |
| loadFault | output | 1 | Width detection failed; held until reset |
| addrWidth | output | 4 | Detected address width W |

## Verification
The bound checker watches properties that must hold on every cycle:
- the shift clock is gated by chip select;
- eeDi is stable while the clock is high;
- the word strobe lasts exactly one cycle;
- chip select stays low for the minimum time between frames;
- the done and fault flags latch and never appear together;
- every delivered address fits the detected width.

Some behaviour only shows up in the bench's scenarios, which use a behavioural memory model with a chosen width and random contents. These scenarios cover the content and order of the words, the width found by the dummy-zero search, the reuse of the detection read as word 0, the exact strobe and done cycles, and the two fault cases (a zero that comes too early, and no zero at all).

// File: rtl/mwl_pkg.sv
package mwl_pkg;

  // read opcode placed after the start bit of each frame
  localparam logic [1:0] READ_OP = 2'b10;
  // start bit plus opcode bits ahead of the address field
  localparam int HDR_BITS = 1 + $bits(READ_OP);

  typedef enum logic [2:0] {
    ST_GAP,
    ST_CMD,
    ST_DATA,
    ST_DONE,
    ST_FAULT
  } mwlState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic csOn;       // chip select level
    logic driveCmd;   // command register drives eeDi
    logic loadCmd;    // load a new command frame
    logic shiftCmd;   // advance the command register one bit
    logic shiftData;  // data phase: capture eeDo samples
    logic cntClr;     // clear the bit counter
    logic cntInc;     // advance the bit counter
    logic latchWidth; // store detected address width
    logic emitWord;   // present the assembled word
    logic addrInc;    // step to the next address
  } mwlStrobe_t;

endpackage

// File: rtl/mwl_datapath.sv
module mwl_datapath
  import mwl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MAX_AW = 8,
  parameter int SK_DIV = 4,
  parameter int AWW    = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  mwlStrobe_t        st,
  input  logic              eeDo,
  output logic              tickEnd,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              sampBit,
  output logic [AWW-1:0]    awReg,
  output logic              lastAddrHit,
  output logic              eeCs,
  output logic              eeSk,
  output logic              eeDi,
  output logic              wordValid,
  output logic [MAX_AW-1:0] wordAddr,
  output logic [DATA_W-1:0] wordData
);

  localparam int PH_W    = $clog2(SK_DIV);
  localparam int FRAME_W = HDR_BITS + MAX_AW;
  localparam int HALF    = SK_DIV / 2;

  logic [PH_W-1:0]    ph;
  logic               tickSample;
  logic [FRAME_W-1:0] cmdSr;
  logic [DATA_W-1:0]  dataSr;
  logic [MAX_AW-1:0]  addr;
  logic [MAX_AW-1:0]  addrField;
  logic [MAX_AW:0]    span;

  // free-running phase of the shift clock
  assign tickEnd    = (ph == PH_W'(SK_DIV - 1));
  assign tickSample = (ph == PH_W'(HALF));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ph <= '0;
    else if (tickEnd) ph <= '0;
    else ph <= ph + PH_W'(1);
  end

  assign eeCs = st.csOn;
  assign eeSk = st.csOn && (ph >= PH_W'(HALF));
  assign eeDi = st.driveCmd && cmdSr[FRAME_W-1];

  // bit counter shared by gap, command and data phases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (st.cntClr) bitCnt <= '0;
    else if (st.cntInc) bitCnt <= bitCnt + CNT_W'(1);
  end

  // address left-justified in the frame so frame length follows awReg
  assign addrField = addr << (MAX_AW - int'(awReg));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdSr <= '0;
    else if (st.loadCmd) cmdSr <= {1'b1, READ_OP, addrField};
    else if (st.shiftCmd) cmdSr <= {cmdSr[FRAME_W-2:0], 1'b0};
  end

  // incoming bit, taken one core cycle after the shift clock rises
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampBit <= 1'b1;
      dataSr  <= '0;
    end else if (tickSample) begin
      sampBit <= eeDo;
      if (st.shiftData) dataSr <= {dataSr[DATA_W-2:0], eeDo};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) awReg <= '0;
    else if (st.latchWidth) awReg <= AWW'(bitCnt - CNT_W'(HDR_BITS - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addr <= '0;
    else if (st.addrInc) addr <= addr + MAX_AW'(1);
  end

  assign span        = (MAX_AW + 1)'(1) << awReg;
  assign lastAddrHit = ({1'b0, addr} == span - (MAX_AW + 1)'(1));

  // word write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordValid <= 1'b0;
      wordAddr  <= '0;
      wordData  <= '0;
    end else begin
      wordValid <= st.emitWord;
      if (st.emitWord) begin
        wordAddr <= addr;
        wordData <= dataSr;
      end
    end
  end

endmodule

// File: rtl/mwl_ctrl.sv
module mwl_ctrl
  import mwl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MIN_AW = 6,
  parameter int MAX_AW = 8,
  parameter int GAP_SK = 2,
  parameter int AWW    = 4,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEnd,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             sampBit,
  input  logic [AWW-1:0]   awReg,
  input  logic             lastAddrHit,
  output mwlStrobe_t       st,
  output logic             loadDone,
  output logic             loadFault
);

  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_SK - 1);
  localparam logic [CNT_W-1:0] ADDR_FST  = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] MIN_LAST  = CNT_W'(HDR_BITS - 1 + MIN_AW);
  localparam logic [CNT_W-1:0] MAX_LAST  = CNT_W'(HDR_BITS - 1 + MAX_AW);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  mwlState_e state, stateNext;
  logic      detecting;
  logic      frameLast;

  // index of the final address bit once the width is known
  assign frameLast = (bitCnt == CNT_W'(HDR_BITS - 1) + CNT_W'(awReg));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_GAP;
    else state <= stateNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) detecting <= 1'b1;
    else if (st.latchWidth) detecting <= 1'b0;
  end

  always_comb begin
    st        = '0;
    stateNext = state;
    unique case (state)
      ST_GAP: begin
        if (tickEnd) begin
          if (bitCnt == GAP_LAST) begin
            st.loadCmd = 1'b1;
            st.cntClr  = 1'b1;
            stateNext  = ST_CMD;
          end else begin
            st.cntInc = 1'b1;
          end
        end
      end
      ST_CMD: begin
        st.csOn     = 1'b1;
        st.driveCmd = 1'b1;
        if (tickEnd) begin
          st.shiftCmd = 1'b1;
          if (detecting) begin
            if (bitCnt >= ADDR_FST && !sampBit) begin
              if (bitCnt < MIN_LAST) begin
                stateNext = ST_FAULT;
              end else begin
                st.latchWidth = 1'b1;
                st.cntClr     = 1'b1;
                stateNext     = ST_DATA;
              end
            end else if (bitCnt == MAX_LAST) begin
              stateNext = ST_FAULT;
            end else begin
              st.cntInc = 1'b1;
            end
          end else if (frameLast) begin
            st.cntClr = 1'b1;
            stateNext = ST_DATA;
          end else begin
            st.cntInc = 1'b1;
          end
        end
      end
      ST_DATA: begin
        st.csOn      = 1'b1;
        st.shiftData = 1'b1;
        if (tickEnd) begin
          if (bitCnt == DATA_LAST) begin
            st.emitWord = 1'b1;
            st.cntClr   = 1'b1;
            if (lastAddrHit) begin
              stateNext = ST_DONE;
            end else begin
              st.addrInc = 1'b1;
              stateNext  = ST_GAP;
            end
          end else begin
            st.cntInc = 1'b1;
          end
        end
      end
      ST_DONE:  stateNext = ST_DONE;
      ST_FAULT: stateNext = ST_FAULT;
      default:  stateNext = ST_FAULT;
    endcase
  end

  assign loadDone  = (state == ST_DONE);
  assign loadFault = (state == ST_FAULT);

endmodule

// File: rtl/mwl_autoload.sv
module mwl_autoload
  import mwl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MIN_AW = 6,
  parameter int MAX_AW = 8,
  parameter int SK_DIV = 4,
  parameter int GAP_SK = 2,
  localparam int AWW   = $clog2(MAX_AW + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              eeCs,
  output logic              eeSk,
  output logic              eeDi,
  input  logic              eeDo,
  output logic              wordValid,
  output logic [MAX_AW-1:0] wordAddr,
  output logic [DATA_W-1:0] wordData,
  output logic              loadDone,
  output logic              loadFault,
  output logic [AWW-1:0]    addrWidth
);

  localparam int CNT_W = $clog2(HDR_BITS + MAX_AW + DATA_W + GAP_SK + 1);

  mwlStrobe_t       st;
  logic             tickEnd;
  logic [CNT_W-1:0] bitCnt;
  logic             sampBit;
  logic             lastAddrHit;

  mwl_ctrl #(
    .DATA_W(DATA_W), .MIN_AW(MIN_AW), .MAX_AW(MAX_AW),
    .GAP_SK(GAP_SK), .AWW(AWW), .CNT_W(CNT_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .tickEnd(tickEnd), .bitCnt(bitCnt),
    .sampBit(sampBit), .awReg(addrWidth), .lastAddrHit(lastAddrHit),
    .st(st), .loadDone(loadDone), .loadFault(loadFault)
  );

  mwl_datapath #(
    .DATA_W(DATA_W), .MAX_AW(MAX_AW), .SK_DIV(SK_DIV),
    .AWW(AWW), .CNT_W(CNT_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .eeDo(eeDo), .tickEnd(tickEnd),
    .bitCnt(bitCnt), .sampBit(sampBit), .awReg(addrWidth),
    .lastAddrHit(lastAddrHit), .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi),
    .wordValid(wordValid), .wordAddr(wordAddr), .wordData(wordData)
  );

endmodule

// File: rtl/mwl_autoload_chk.sv
module mwl_autoload_chk #(
  parameter int MIN_AW = 6,
  parameter int MAX_AW = 8,
  parameter int SK_DIV = 4,
  parameter int GAP_SK = 2,
  parameter int AWW    = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              eeCs,
  input logic              eeSk,
  input logic              eeDi,
  input logic              wordValid,
  input logic [MAX_AW-1:0] wordAddr,
  input logic              loadDone,
  input logic              loadFault,
  input logic [AWW-1:0]    addrWidth
);

  localparam int GAP_MIN = GAP_SK * SK_DIV;
  localparam int GC_W    = $clog2(GAP_MIN + 1);

  logic [GC_W-1:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gapCnt <= '0;
    else if (eeCs) gapCnt <= '0;
    else if (gapCnt != GC_W'(GAP_MIN)) gapCnt <= gapCnt + GC_W'(1);
  end

  // R2
  sk_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !eeCs |-> !eeSk);

  // R2
  di_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    eeSk |-> $stable(eeDi));

  // R6
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> ((wordAddr >> addrWidth) == '0));

  // R7
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeCs) |-> (gapCnt >= GC_W'(GAP_MIN)));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> (loadDone && $stable(addrWidth)));

  // R8
  idle_after_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadDone || loadFault) |-> !eeCs);

  // R4
  width_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> (addrWidth >= AWW'(MIN_AW) && addrWidth <= AWW'(MAX_AW)));

  // R9
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadFault |=> loadFault);

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(loadDone && loadFault));

endmodule

bind mwl_autoload mwl_autoload_chk #(
  .MIN_AW(MIN_AW), .MAX_AW(MAX_AW), .SK_DIV(SK_DIV),
  .GAP_SK(GAP_SK), .AWW(AWW)
) i_mwl_autoload_chk (
  .clk(clk), .rstN(rstN), .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi),
  .wordValid(wordValid), .wordAddr(wordAddr), .loadDone(loadDone),
  .loadFault(loadFault), .addrWidth(addrWidth)
);

// File: tb/test_mwl_autoload.sv
module test_mwl_autoload;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_AW     = 8;
  localparam int DATA_W     = 16;
  localparam int SKD        = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              eeCs, eeSk, eeDi;
  logic              eeDoR = 1'b1;
  logic              wordValid;
  logic [MAX_AW-1:0] wordAddr;
  logic [DATA_W-1:0] wordData;
  logic              loadDone, loadFault;
  logic [3:0]        addrWidth;

  mwl_autoload i_mwl_autoload (
    .clk(clk), .rstN(rstN), .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi),
    .eeDo(eeDoR), .wordValid(wordValid), .wordAddr(wordAddr),
    .wordData(wordData), .loadDone(loadDone), .loadFault(loadFault),
    .addrWidth(addrWidth)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nTotal = 0, nBad = 0;
  int monTotal = 0, monBad = 0;
  int memW = 6;
  logic [15:0] memSeed = 16'h0;

  function automatic logic [15:0] memWord(input int a, input logic [15:0] s);
    logic [15:0] x;
    x = 16'(a);
    return s ^ (x * 16'h3B1D) ^ {x[7:0], x[15:8]} ^ 16'h5A0F;
  endfunction

  // behavioural serial EEPROM of width memW
  int          rxCnt = 0;
  int          rxAddr = 0;
  logic        rxStart = 1'b0;
  logic [1:0]  rxOp = 2'b00;
  int          lastRxAddr = -1;
  logic        lastRxStart = 1'b0;
  logic [1:0]  lastRxOp = 2'b00;

  always @(posedge eeSk or negedge eeCs) begin
    if (!eeCs) begin
      rxCnt  = 0;
      rxAddr = 0;
      eeDoR <= 1'b1;
    end else begin
      logic [15:0] w;
      if (rxCnt == 0) rxStart = eeDi;
      else if (rxCnt <= 2) rxOp = {rxOp[0], eeDi};
      else if (rxCnt <= 2 + memW) rxAddr = (rxAddr << 1) | int'(eeDi);
      if (rxCnt == 2 + memW) begin
        eeDoR <= 1'b0;
        lastRxAddr  = rxAddr;
        lastRxStart = rxStart;
        lastRxOp    = rxOp;
      end else if (rxCnt > 2 + memW && rxCnt <= 18 + memW) begin
        w = memWord(rxAddr, memSeed);
        eeDoR <= w[15 - (rxCnt - 3 - memW)];
      end else begin
        eeDoR <= 1'b1;
      end
      rxCnt++;
    end
  end

  // port monitor
  int cyc = 0;
  int expIdx = 0;
  bit doneSeen = 0, faultSeen = 0;
  int doneCyc = 0, faultCyc = 0;
  int r2Bad = 0, r7Bad = 0;
  int skHigh = 0, skLow = 0, csLow = 0;
  logic prevSk = 1'b0, prevDi = 1'b0, prevCs = 1'b0;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (!rstN) begin
      expIdx = 0; doneSeen = 0; faultSeen = 0;
      skHigh = 0; skLow = 0; csLow = 0;
      prevSk = 1'b0; prevDi = 1'b0; prevCs = 1'b0;
    end else begin
      if (wordValid) begin
        logic [15:0] expD;
        int expCyc;
        expD   = memWord(expIdx, memSeed);
        expCyc = SKD * (21 + memW) * (expIdx + 1);
        monTotal += 4;
        if (int'(wordAddr) != expIdx) begin
          monBad++;
          $display("FAIL R6 word address act=%0d exp=%0d", wordAddr, expIdx);
        end
        if (wordData != expD) begin
          monBad++;
          if (expIdx == 0)
            $display("FAIL R5 detection word act=%h exp=%h", wordData, expD);
          else
            $display("FAIL R3 word data act=%h exp=%h", wordData, expD);
        end
        if (lastRxAddr != expIdx || lastRxOp != 2'b10 || lastRxStart != 1'b1) begin
          monBad++;
          $display("FAIL R3 frame addr/op/start act=%0d/%b/%b exp=%0d/10/1",
                   lastRxAddr, lastRxOp, lastRxStart, expIdx);
        end
        if (cyc != expCyc) begin
          monBad++;
          $display("FAIL R10 strobe cycle act=%0d exp=%0d", cyc, expCyc);
        end
        expIdx++;
      end
      if (loadDone && !doneSeen) begin doneSeen = 1; doneCyc = cyc; end
      if (loadFault && !faultSeen) begin faultSeen = 1; faultCyc = cyc; end
      // R2 monitor
      if (eeSk && !eeCs) r2Bad++;
      if (eeSk && prevSk && eeDi != prevDi) r2Bad++;
      if (prevSk && !eeSk && skHigh != 2) r2Bad++;
      if (!prevSk && eeSk && skLow != 2) r2Bad++;
      if (eeSk) begin skHigh++; skLow = 0; end
      else begin skHigh = 0; skLow = eeCs ? skLow + 1 : 0; end
      // R7 monitor
      if (eeCs && !prevCs && csLow < 8) r7Bad++;
      csLow = eeCs ? 0 : csLow + 1;
      prevSk = eeSk; prevDi = eeDi; prevCs = eeCs;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTotal++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic runLoad(input int w, input bit expFault, input int nSent);
    int guard;
    @(negedge clk);
    rstN = 1'b0;
    memW = w;
    memSeed = 16'($urandom);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!eeCs && !eeSk && !eeDi, "R1", "serial pins in reset", int'({eeCs, eeSk, eeDi}), 0);
    check(!wordValid && !loadDone && !loadFault, "R1", "flags in reset",
          int'({wordValid, loadDone, loadFault}), 0);
    check(addrWidth == 0, "R1", "addrWidth in reset", int'(addrWidth), 0);
    rstN = 1'b1;
    guard = 0;
    while (!(loadDone || loadFault) && guard < 60000) begin
      @(negedge clk);
      guard++;
    end
    repeat (24) @(negedge clk);
    if (!expFault) begin
      check(loadDone && !loadFault, "R8", "done flag", int'(loadDone), 1);
      check(expIdx == (1 << w), "R6", "word count", expIdx, 1 << w);
      check(int'(addrWidth) == w, "R4", "detected width", int'(addrWidth), w);
      check(doneCyc == SKD * (21 + w) * (1 << w), "R10", "done cycle",
            doneCyc, SKD * (21 + w) * (1 << w));
      check(!eeCs, "R8", "chip select idle after done", int'(eeCs), 0);
    end else begin
      check(loadFault && !loadDone, "R9", "fault flag", int'(loadFault), 1);
      check(expIdx == 0, "R9", "no words on fault", expIdx, 0);
      check(addrWidth == 0, "R9", "width stays 0", int'(addrWidth), 0);
      check(faultCyc == SKD * (5 + nSent), "R9", "fault cycle", faultCyc, SKD * (5 + nSent));
      check(!eeCs, "R9", "chip select idle after fault", int'(eeCs), 0);
    end
    check(r2Bad == 0, "R2", "shift clock shape violations", r2Bad, 0);
    check(r7Bad == 0, "R7", "short chip-select gaps", r7Bad, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    runLoad(6, 1'b0, 0);
    runLoad(7, 1'b0, 0);
    runLoad(8, 1'b0, 0);
    runLoad(9, 1'b1, 8);   // no dummy zero within 8 address bits
    runLoad(5, 1'b1, 5);   // dummy zero too early
    runLoad(int'($urandom_range(8, 6)), 1'b0, 0);
    $display("  test done: total=%0d bad=%0d", nTotal + monTotal, nBad + monBad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", nTotal + monTotal + 1, nBad + monBad + 1);
    $finish;
  end

endmodule